// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside the control path of a simple 32-bit processor core and decides which of seven pending exception kinds is taken. The kinds are reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. For the winning kind it produces everything the core needs to switch context:
- the vector fetch address;
- the new status word, with its mode field and interrupt masks updated;
- the status copy to bank into the new mode;
- the link value to bank into the new mode;
- a one-cycle redirect strobe.

On a return strobe it produces the resume address and restores the status word from the banked copy. The resume address is the link value minus an offset that depends on the kind of exception being left.

The core owns the register file, the pipeline and memory. It presents its current status word, its program counter, and the banked link and status values of the current mode at the ports. It applies the block's outputs in the cycle the redirect strobe is high. While the strobe is high, new requests are not arbitrated, because the core has not yet taken in the new masks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, the redirect strobe and the bank write strobe are both 0 until a request or return strobe is seen.
- R2: Fixed priority applies, from highest to lowest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. When several requests are present in one cycle, only the highest is taken. Undefined instruction wins over software interrupt.
- R3: A normal interrupt request is ignored while status bit 7 (I mask) is 1. A fast interrupt request is ignored while status bit 6 (F mask) is 1. Either mask is cleared to 0 to accept its request.
- R4: The new status word's mode field, bits [4:0], is fixed per kind:
  - fast interrupt 10001;
  - normal interrupt 10010;
  - reset and software interrupt 10011;
  - both aborts 10111;
  - undefined 11011.
- R5: The vector address is fixed per kind: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R6: On every entry the new status word has bit 7 set. Bit 6 is set for reset and fast interrupt and copied unchanged for all other kinds. Bits [31:8] and bit 5 are copied from the current status word.
- R7: On entry the bank write strobe is 1, the link value is the current program counter plus 4, and the banked status copy equals the current status word.
- R8: An entry appears on the outputs in the cycle after the request is sampled. Redirect is high for exactly one cycle. A request held through the redirect cycle causes no second entry.
- R9: A return strobe gives, one cycle later, redirect with bank write strobe 0. The new status word equals the saved status input. The resume address is the link input minus an offset chosen by the current mode field:
  - 4 in fast interrupt or normal interrupt mode;
  - in abort mode, 8 if the last abort taken was a data abort and 4 if it was a prefetch abort;
  - 0 in every other mode.
- R10: If an accepted request and a return strobe arrive in the same cycle, the entry is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| cur_psr | input | 32 | Current status word |
| cur_pc | input | 32 | Current program counter |
| ret_strobe | input | 1 | Return from exception request |
| link_in | input | 32 | Banked link value of the current mode |
| saved_psr_in | input | 32 | Banked status copy of the current mode |
| redirect | output | 1 | One-cycle strobe: core loads new PC and status |
| bank_we | output | 1 | Entry strobe: bank link and status copy into new mode |
| vec_addr | output | 32 | Vector fetch address on entry |
| new_psr | output | 32 | Status word to load on redirect |
| spsr_wr | output | 32 | Status copy to bank on entry |
| link_wr | output | 32 | Link value to bank on entry |
| ret_pc | output | 32 | Resume address on return |

## Verification
Entries and returns are both due exactly one cycle after the inputs are sampled. The bench drives stimulus on a falling edge and holds it for one cycle. It pushes the expected item into a scoreboard queue at that moment. A monitor pops the item on the next falling edge, which is the only time the registered strobe is high.

Any redirect that arrives with the queue empty is counted as a failure. This covers masked interrupts, dropped returns and a request held through the redirect cycle. It also proves that no output moves a cycle early or late.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NKIND = 7;
  localparam int I_BIT = 7;
  localparam int F_BIT = 6;
  localparam int MODE_W = 5;

  // index order is the priority order (0 = highest)
  typedef enum logic [2:0] {
    K_RST  = 3'd0,
    K_DABT = 3'd1,
    K_FIQ  = 3'd2,
    K_IRQ  = 3'd3,
    K_PABT = 3'd4,
    K_UND  = 3'd5,
    K_SWI  = 3'd6
  } kind_e;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  function automatic logic [MODE_W-1:0] mode_of(kind_e k);
    case (k)
      K_FIQ:         return M_FIQ;
      K_IRQ:         return M_IRQ;
      K_DABT, K_PABT: return M_ABT;
      K_UND:         return M_UND;
      default:       return M_SVC;
    endcase
  endfunction

  function automatic logic [7:0] vec_off(kind_e k);
    case (k)
      K_UND:   return 8'h04;
      K_SWI:   return 8'h08;
      K_PABT:  return 8'h0C;
      K_DABT:  return 8'h10;
      K_IRQ:   return 8'h18;
      K_FIQ:   return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic sets_fmask(kind_e k);
    return (k == K_RST) || (k == K_FIQ);
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NK = NKIND,
  localparam int IW = $clog2(NK)
) (
  input  logic [NK-1:0] req,
  input  logic          en,
  output logic          take,
  output logic [IW-1:0] win
);
  logic [NK:0]   blocked;
  logic [NK-1:0] grant;

  assign blocked[0] = 1'b0;
  for (genvar g = 0; g < NK; g++) begin : g_lane
    assign grant[g]     = en & req[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | req[g];
  end

  always_comb begin
    win = '0;
    for (int i = 0; i < NK; i++) begin
      if (grant[i]) win = win | IW'(i);
    end
  end

  assign take = |grant;
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  kind_e         kind,
  input  logic [DW-1:0] psr_in,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] vec,
  output logic [DW-1:0] psr_out,
  output logic [DW-1:0] link
);
  always_comb begin
    psr_out               = psr_in;
    psr_out[MODE_W-1:0]   = mode_of(kind);
    psr_out[I_BIT]        = 1'b1;
    psr_out[F_BIT]        = psr_in[F_BIT] | sets_fmask(kind);
  end

  assign vec  = DW'(VEC_BASE) + DW'(vec_off(kind));
  assign link = pc_in + DW'(4);
endmodule

// File: rtl/exc_return_calc.sv
module exc_return_calc
  import exc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              abt_was_data,
  input  logic [DW-1:0]     link,
  output logic [DW-1:0]     ret_pc
);
  logic [3:0] off;

  always_comb begin
    case (mode)
      M_FIQ, M_IRQ: off = 4'd4;
      M_ABT:        off = abt_was_data ? 4'd8 : 4'd4;
      default:      off = 4'd0;
    endcase
  end

  assign ret_pc = link - DW'(off);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rst,
  input  logic          req_dabt,
  input  logic          req_fiq,
  input  logic          req_irq,
  input  logic          req_pabt,
  input  logic          req_und,
  input  logic          req_swi,
  input  logic [DW-1:0] cur_psr,
  input  logic [DW-1:0] cur_pc,
  input  logic          ret_strobe,
  input  logic [DW-1:0] link_in,
  input  logic [DW-1:0] saved_psr_in,
  output logic          redirect,
  output logic          bank_we,
  output logic [DW-1:0] vec_addr,
  output logic [DW-1:0] new_psr,
  output logic [DW-1:0] spsr_wr,
  output logic [DW-1:0] link_wr,
  output logic [DW-1:0] ret_pc
);
  localparam int IW = $clog2(NKIND);

  logic [NKIND-1:0] req_vec;
  logic             take;
  logic [IW-1:0]    win;
  kind_e            kind;
  logic [DW-1:0]    e_vec, e_psr, e_link, r_pc;

  logic          redirect_q, redirect_d;
  logic          bank_we_q, bank_we_d;
  logic [DW-1:0] vec_q, vec_d, psr_q, psr_d, spsr_q, spsr_d;
  logic [DW-1:0] link_q, link_d, rpc_q, rpc_d;
  logic          abt_data_q, abt_data_d;
  logic          ent_en, ret_en;
  logic          do_ret;

  // masked request lines, priority order
  assign req_vec = {req_swi, req_und, req_pabt,
                    req_irq & ~cur_psr[I_BIT],
                    req_fiq & ~cur_psr[F_BIT],
                    req_dabt, req_rst};

  exc_arbiter #(.NK(NKIND)) u_arb (
    .req  (req_vec),
    .en   (~redirect_q),
    .take (take),
    .win  (win)
  );

  assign kind = kind_e'(win);

  exc_entry_calc #(.DW(DW), .VEC_BASE(VEC_BASE)) u_ent (
    .kind    (kind),
    .psr_in  (cur_psr),
    .pc_in   (cur_pc),
    .vec     (e_vec),
    .psr_out (e_psr),
    .link    (e_link)
  );

  exc_return_calc #(.DW(DW)) u_ret (
    .mode         (cur_psr[MODE_W-1:0]),
    .abt_was_data (abt_data_q),
    .link         (link_in),
    .ret_pc       (r_pc)
  );

  assign do_ret = ret_strobe & ~redirect_q & ~take;

  // next state
  always_comb begin
    redirect_d = take | do_ret;
    bank_we_d  = take;
    ent_en     = take;
    ret_en     = do_ret;
    vec_d      = vec_q;
    spsr_d     = spsr_q;
    link_d     = link_q;
    rpc_d      = rpc_q;
    psr_d      = psr_q;
    abt_data_d = abt_data_q;
    if (ent_en) begin
      vec_d  = e_vec;
      psr_d  = e_psr;
      spsr_d = cur_psr;
      link_d = e_link;
      if (kind == K_DABT) abt_data_d = 1'b1;
      if (kind == K_PABT) abt_data_d = 1'b0;
    end else if (ret_en) begin
      psr_d = saved_psr_in;
      rpc_d = r_pc;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_q <= 1'b0;
      bank_we_q  <= 1'b0;
      vec_q      <= '0;
      psr_q      <= '0;
      spsr_q     <= '0;
      link_q     <= '0;
      rpc_q      <= '0;
      abt_data_q <= 1'b0;
    end else begin
      redirect_q <= redirect_d;
      bank_we_q  <= bank_we_d;
      vec_q      <= vec_d;
      psr_q      <= psr_d;
      spsr_q     <= spsr_d;
      link_q     <= link_d;
      rpc_q      <= rpc_d;
      abt_data_q <= abt_data_d;
    end
  end

  assign redirect = redirect_q;
  assign bank_we  = bank_we_q;
  assign vec_addr = vec_q;
  assign new_psr  = psr_q;
  assign spsr_wr  = spsr_q;
  assign link_wr  = link_q;
  assign ret_pc   = rpc_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_rst,
  input logic          req_dabt,
  input logic          req_fiq,
  input logic          req_irq,
  input logic          req_pabt,
  input logic          req_und,
  input logic          req_swi,
  input logic [DW-1:0] cur_psr,
  input logic [DW-1:0] cur_pc,
  input logic          ret_strobe,
  input logic [DW-1:0] saved_psr_in,
  input logic          redirect,
  input logic          bank_we,
  input logic [DW-1:0] new_psr,
  input logic [DW-1:0] spsr_wr,
  input logic [DW-1:0] link_wr
);
  logic any_req;
  assign any_req = req_rst | req_dabt | req_fiq | req_irq | req_pabt | req_und | req_swi;

  AST_BANK_NEEDS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> redirect);                                           // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);                                         // R8
  AST_CAUSE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redirect) |-> $past(any_req | ret_strobe));                // R8
  AST_ENTRY_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> new_psr[I_BIT]);                                     // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we && new_psr[MODE_W-1:0] == M_IRQ) |-> !$past(cur_psr[I_BIT])); // R3
  AST_FIQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we && new_psr[MODE_W-1:0] == M_FIQ) |-> !$past(cur_psr[F_BIT])); // R3
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> link_wr == $past(cur_pc) + DW'(4));                  // R7
  AST_SPSR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> spsr_wr == $past(cur_psr));                          // R7
  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !bank_we) |-> new_psr == $past(saved_psr_in));      // R9
endmodule

bind exc_entry_ctrl exc_entry_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_rst      (req_rst),
  .req_dabt     (req_dabt),
  .req_fiq      (req_fiq),
  .req_irq      (req_irq),
  .req_pabt     (req_pabt),
  .req_und      (req_und),
  .req_swi      (req_swi),
  .cur_psr      (cur_psr),
  .cur_pc       (cur_pc),
  .ret_strobe   (ret_strobe),
  .saved_psr_in (saved_psr_in),
  .redirect     (redirect),
  .bank_we      (bank_we),
  .new_psr      (new_psr),
  .spsr_wr      (spsr_wr),
  .link_wr      (link_wr)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk, rst_n;
  logic req_rst, req_dabt, req_fiq, req_irq, req_pabt, req_und, req_swi;
  logic [31:0] cur_psr, cur_pc, link_in, saved_psr_in;
  logic ret_strobe;
  logic redirect, bank_we;
  logic [31:0] vec_addr, new_psr, spsr_wr, link_wr, ret_pc;

  exc_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_rst(req_rst), .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
    .req_pabt(req_pabt), .req_und(req_und), .req_swi(req_swi),
    .cur_psr(cur_psr), .cur_pc(cur_pc), .ret_strobe(ret_strobe),
    .link_in(link_in), .saved_psr_in(saved_psr_in),
    .redirect(redirect), .bank_we(bank_we), .vec_addr(vec_addr),
    .new_psr(new_psr), .spsr_wr(spsr_wr), .link_wr(link_wr), .ret_pc(ret_pc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    bit          entry;
    logic [31:0] vec, psr, spsr, link, rpc;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit abt_d = 0;

  // request bit order: 0 rst,1 dabt,2 fiq,3 irq,4 pabt,5 und,6 swi
  localparam logic [4:0] MU = 5'b10000, MF = 5'b10001, MI = 5'b10010,
                         MS = 5'b10011, MA = 5'b10111, MD = 5'b11011;

  task automatic chk(input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] emode(int k);
    case (k) 0: return MS; 1: return MA; 2: return MF; 3: return MI;
      4: return MA; 5: return MD; default: return MS; endcase
  endfunction
  function automatic logic [31:0] evec(int k);
    case (k) 0: return 32'h00; 1: return 32'h10; 2: return 32'h1C; 3: return 32'h18;
      4: return 32'h0C; 5: return 32'h04; default: return 32'h08; endcase
  endfunction

  task automatic stim(input logic [6:0] r, input logic [31:0] psr, pc,
                      input logic ret, input logic [31:0] lnk, sp, input string tag);
    item_t it;
    int win = -1;
    logic [6:0] m;
    m = r;
    if (psr[7]) m[3] = 1'b0;
    if (psr[6]) m[2] = 1'b0;
    for (int i = 6; i >= 0; i--) if (m[i]) win = i;
    @(negedge clk);
    {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = r;
    cur_psr = psr; cur_pc = pc; ret_strobe = ret; link_in = lnk; saved_psr_in = sp;
    it.tag = tag; it.vec = 0; it.rpc = 0; it.spsr = 0; it.link = 0;
    if (win >= 0) begin
      it.entry = 1;
      it.vec = evec(win);
      it.psr = {psr[31:8], 1'b1, psr[6] | (win == 0 || win == 2), psr[5], emode(win)};
      it.spsr = psr; it.link = pc + 4;
      if (win == 1) abt_d = 1;
      if (win == 4) abt_d = 0;
      q.push_back(it);
    end else if (ret) begin
      int off;
      case (psr[4:0]) MF, MI: off = 4; MA: off = abt_d ? 8 : 4; default: off = 0; endcase
      it.entry = 0; it.psr = sp; it.rpc = lnk - off;
      q.push_back(it);
    end
    @(negedge clk);
    {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = '0;
    ret_strobe = 0;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && redirect) begin
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8 unexpected redirect actual=1 expected=0");
      end else begin
        item_t e;
        e = q.pop_front();
        chk({e.tag, " bank_we"}, {31'd0, bank_we}, {31'd0, e.entry});
        chk({e.tag, " new_psr"}, new_psr, e.psr);
        if (e.entry) begin
          chk({e.tag, " vec_addr"}, vec_addr, e.vec);
          chk({e.tag, " spsr_wr"}, spsr_wr, e.spsr);
          chk({e.tag, " link_wr"}, link_wr, e.link);
        end else begin
          chk({e.tag, " ret_pc"}, ret_pc, e.rpc);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [31:0] PU = 32'hA000_0010;  // user, I=F=0
  initial begin
    rst_n = 0;
    {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = '0;
    cur_psr = PU; cur_pc = 0; ret_strobe = 0; link_in = 0; saved_psr_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 redirect after reset", {31'd0, redirect}, 32'd0);
    chk("R1 bank_we after reset", {31'd0, bank_we}, 32'd0);

    // single kinds: R4 R5 R6 R7
    for (int k = 0; k < 7; k++)
      stim(7'(1 << k), PU, 32'h100 + 32'(k * 16), 0, 0, 0, "R4/R5/R6/R7 single");
    // F kept when already set on a non-fast kind (R6)
    stim(7'b000_1000, PU | 32'h40, 32'h200, 0, 0, 0, "R6 F kept on irq");
    stim(7'b000_0010, PU | 32'h40, 32'h204, 0, 0, 0, "R6 F kept on dabt");

    // priority R2
    stim(7'b111_1111, PU, 32'h300, 0, 0, 0, "R2 all");
    stim(7'b111_1110, PU, 32'h304, 0, 0, 0, "R2 dabt");
    stim(7'b111_1100, PU, 32'h308, 0, 0, 0, "R2 fiq");
    stim(7'b111_1000, PU, 32'h30C, 0, 0, 0, "R2 irq");
    stim(7'b111_0000, PU, 32'h310, 0, 0, 0, "R2 pabt");
    stim(7'b110_0000, PU, 32'h314, 0, 0, 0, "R2 und over swi");

    // masks R3
    stim(7'b000_1000, PU | 32'h80, 32'h400, 0, 0, 0, "R3 irq masked");
    stim(7'b000_0100, PU | 32'h40, 32'h404, 0, 0, 0, "R3 fiq masked");
    stim(7'b000_0100, PU | 32'h80, 32'h408, 0, 0, 0, "R3 fiq with I set");
    stim(7'b000_1100, PU | 32'h40, 32'h40C, 0, 0, 0, "R3 fiq masked irq wins");

    // returns R9
    stim(0, 32'h2000_00D2, 0, 1, 32'h1000, 32'h1111_0010, "R9 irq return");
    stim(0, 32'h2000_00D1, 0, 1, 32'h1100, 32'h2222_0010, "R9 fiq return");
    stim(0, 32'h2000_00D3, 0, 1, 32'h1200, 32'h3333_0010, "R9 svc return");
    stim(0, 32'h2000_00DB, 0, 1, 32'h1300, 32'h4444_0010, "R9 und return");
    stim(7'b000_0010, PU, 32'h500, 0, 0, 0, "R9 dabt entry");
    stim(0, 32'h2000_00D7, 0, 1, 32'h1400, 32'h5555_0010, "R9 dabt return");
    stim(7'b001_0000, PU, 32'h504, 0, 0, 0, "R9 pabt entry");
    stim(0, 32'h2000_00D7, 0, 1, 32'h1500, 32'h6666_0010, "R9 pabt return");

    // collision R10
    stim(7'b000_1000, PU, 32'h600, 1, 32'h1600, 32'h7777_0010, "R10 entry wins");

    // held request R8
    @(negedge clk);
    begin
      item_t it;
      it.entry = 1; it.vec = 32'h18; it.psr = {PU[31:8], 1'b1, 1'b0, PU[5], MI};
      it.spsr = PU; it.link = 32'h704; it.rpc = 0; it.tag = "R8 held irq";
      q.push_back(it);
    end
    req_irq = 1; cur_psr = PU; cur_pc = 32'h700;
    @(negedge clk);
    chk("R8 redirect in cycle after request", {31'd0, redirect}, 32'd1);
    @(negedge clk);
    req_irq = 0;
    chk("R8 no second entry", {31'd0, redirect}, 32'd0);
    repeat (2) @(negedge clk);

    chk("R8 scoreboard drained", 32'(q.size()), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule